// File: doc/BRIEF.md
# Miss-Shadow Speculation Controller

This block keeps the head of a small in-order window moving while a load waits on a second-level cache miss. When the oldest entry is a load and the miss flag is up, the block copies the register file, the branch history register and the return stack into a snapshot. It then switches to a speculative mode. In that mode every head entry leaves the window in program order. A per-register invalid bit carries the miss result forward to every instruction that depends on it. Stores never leave the block. Loads whose address is valid but which miss are sent out as prefetches.

When the fill for the triggering miss arrives, the block enters a one-cycle restore state. In that cycle it flushes the pipeline, reloads the snapshot and redirects fetch to the triggering load. It then returns to normal operation. A counter reports how many instructions left the window during the speculative period.

Opcodes on `head_op_i`:

| Code | Operation |
|------|-----------|
| 0 | add: dst = a + b |
| 1 | load: address is a, data comes from `ld_data_i` |
| 2 | store: address is a, data is b |
| 3 | branch: shifts `head_taken_i` into the history LSB |
| 4 | call: pushes pc+4 onto the return stack |
| 5 | return: pops the return stack |

Top module: `miss_shadow_ctrl`

## Requirements
- R1: After reset, `mode_o` is 0, every register reads 0 with its invalid bit clear, the history is 0, the return-stack top is 0 and the counter is 0.
- R2: In normal mode (`mode_o`=0), a popped add writes a+b and a popped load hit writes `ld_data_i`. A store pulses `st_valid_o` with address a and data b. A branch shifts `head_taken_i` into the history LSB. A call pushes pc+4 onto a circular 4-entry return stack, and a return pops it.
- R3: Entry takes place only in normal mode, with a valid head that is a load while `miss_i` is high. That load is popped and its destination is marked invalid. `mode_o` becomes 1 on the next cycle.
- R4: In speculative mode an add's result is invalid exactly when a source is invalid. A load's result is invalid when its address register is invalid or it misses. A valid result clears the invalid bit.
- R5: In speculative mode every valid head is popped in the same cycle unless `fill_i` is high, and `st_valid_o` never pulses.
- R6: A load that misses in speculative mode with a valid address pulses `pf_valid_o` with that address. The mode stays 1 and no new snapshot is taken.
- R7: `fill_i` in speculative mode blocks the pop in that cycle. The next cycle has `mode_o`=2 for exactly one cycle, with `flush_o` and `redirect_o` high and `redirect_pc_o` equal to the triggering load's pc. `head_ready_o` is low in that cycle, and `mode_o` is 0 on the cycle after.
- R8: After restore, the registers, the history and the return stack hold their values from the entry cycle, and all invalid bits are clear.
- R9: `spec_cnt_o` is cleared on entry, increases by one per pop in speculative mode, and otherwise holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low async reset |
| head_valid_i | input | 1 | window head holds an instruction |
| head_op_i | input | 3 | head opcode |
| head_dst_i | input | 3 | destination register |
| head_src_a_i | input | 3 | source a / address register |
| head_src_b_i | input | 3 | source b / store data register |
| head_pc_i | input | 16 | head pc |
| head_taken_i | input | 1 | branch outcome |
| miss_i | input | 1 | head load misses in second-level cache |
| ld_data_i | input | 16 | load hit data |
| fill_i | input | 1 | triggering miss completed |
| rd_addr_i | input | 3 | observation read address |
| head_ready_o | output | 1 | head popped this cycle |
| rd_data_o | output | 16 | register value at rd_addr_i |
| rd_inv_o | output | 1 | invalid bit at rd_addr_i |
| bhr_o | output | 8 | branch history |
| ras_top_o | output | 16 | return stack top |
| st_valid_o | output | 1 | store to memory |
| st_addr_o | output | 16 | store address |
| st_data_o | output | 16 | store data |
| pf_valid_o | output | 1 | prefetch request |
| pf_addr_o | output | 16 | prefetch address |
| mode_o | output | 2 | 0 normal, 1 speculative, 2 restore |
| flush_o | output | 1 | pipeline flush |
| redirect_o | output | 1 | fetch redirect |
| redirect_pc_o | output | 16 | redirect target |
| spec_cnt_o | output | 16 | instructions popped in speculative mode |

## Verification
The assertions assume that `fill_i` refers only to the miss that triggered entry. They also assume that the opcode, register fields and miss flag are stable for the whole cycle in which they are sampled. The stimulus drives every input once per cycle, on the falling edge. It raises `fill_i` at random while speculative mode is active, and at random otherwise, which covers the rule that fill is ignored outside speculative mode. Random sequences of all six opcodes, with frequent misses, are mixed with a directed chain of dependent instructions that covers poisoning, a dropped store, a blocked prefetch and an issued prefetch.

// File: rtl/msc_pkg.sv
package msc_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2,
    OP_BRANCH = 3'd3, OP_CALL = 3'd4, OP_RET = 3'd5
  } op_e;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0, MODE_SPEC = 2'd1, MODE_RESTORE = 2'd2
  } mode_e;
endpackage

// File: rtl/msc_mode_fsm.sv
module msc_mode_fsm
  import msc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_valid_i,
  input  logic             is_load_i,
  input  logic             miss_i,
  input  logic             fill_i,
  input  logic [PC_W-1:0]  head_pc_i,
  output mode_e            mode_o,
  output logic             pop_o,
  output logic             enter_o,
  output logic             restore_o,
  output logic [PC_W-1:0]  trig_pc_o,
  output logic [CNT_W-1:0] cnt_o
);
  mode_e mode_q, mode_d;
  logic [PC_W-1:0]  trig_q;
  logic [CNT_W-1:0] cnt_q;

  assign pop_o     = head_valid_i && (mode_q == MODE_NORMAL || (mode_q == MODE_SPEC && !fill_i));
  assign enter_o   = pop_o && mode_q == MODE_NORMAL && is_load_i && miss_i;
  assign restore_o = mode_q == MODE_RESTORE;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL:  if (enter_o) mode_d = MODE_SPEC;
      MODE_SPEC:    if (fill_i)  mode_d = MODE_RESTORE;
      default:                   mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NORMAL;
      trig_q <= '0;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (enter_o) begin
        trig_q <= head_pc_i;
        cnt_q  <= '0;
      end else if (mode_q == MODE_SPEC && pop_o) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mode_o    = mode_q;
  assign trig_pc_o = trig_q;
  assign cnt_o     = cnt_q;

  // R3
  entry_to_spec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> mode_q == MODE_SPEC);
  // R7
  restore_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_RESTORE |=> mode_q == MODE_NORMAL);
  // R7
  fill_to_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SPEC && fill_i) |=> mode_q == MODE_RESTORE);
  // R9
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> cnt_q == '0);
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_SPEC && !enter_o) |=> $stable(cnt_q));
endmodule

// File: rtl/msc_regfile.sv
module msc_regfile #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            winv_i,
  input  logic            save_i,
  input  logic            restore_i,
  input  logic [AW-1:0]   ra_i,
  input  logic [AW-1:0]   rb_i,
  input  logic [AW-1:0]   rc_i,
  output logic [XLEN-1:0] da_o,
  output logic [XLEN-1:0] db_o,
  output logic [XLEN-1:0] dc_o,
  output logic            ia_o,
  output logic            ib_o,
  output logic            ic_o
);
  logic [XLEN-1:0] rf_q [NREG];
  logic [XLEN-1:0] ck_q [NREG];
  logic [NREG-1:0] inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) begin
        rf_q[i] <= '0;
        ck_q[i] <= '0;
      end
      inv_q <= '0;
    end else if (restore_i) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= ck_q[i];
      inv_q <= '0;
    end else begin
      if (save_i) for (int i = 0; i < NREG; i++) ck_q[i] <= rf_q[i];
      if (we_i) begin
        rf_q[waddr_i]  <= wdata_i;
        inv_q[waddr_i] <= winv_i;
      end
    end
  end

  assign da_o = rf_q[ra_i];
  assign db_o = rf_q[rb_i];
  assign dc_o = rf_q[rc_i];
  assign ia_o = inv_q[ra_i];
  assign ib_o = inv_q[rb_i];
  assign ic_o = inv_q[rc_i];

  // R8
  restore_clears_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> inv_q == '0);
  // R3
  save_restore_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(save_i && restore_i));
endmodule

// File: rtl/msc_hist.sv
module msc_hist #(
  parameter int BHR_W = 8,
  parameter int RAS_D = 4,
  parameter int PC_W  = 16,
  localparam int SPW = $clog2(RAS_D)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            br_i,
  input  logic            taken_i,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic [PC_W-1:0] ret_addr_i,
  input  logic            save_i,
  input  logic            restore_i,
  output logic [BHR_W-1:0] bhr_o,
  output logic [PC_W-1:0]  top_o
);
  logic [BHR_W-1:0] bhr_q, ck_bhr_q;
  logic [PC_W-1:0]  ras_q [RAS_D];
  logic [PC_W-1:0]  ck_ras_q [RAS_D];
  logic [SPW-1:0]   sp_q, ck_sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bhr_q    <= '0;
      ck_bhr_q <= '0;
      sp_q     <= '0;
      ck_sp_q  <= '0;
      for (int i = 0; i < RAS_D; i++) begin
        ras_q[i]    <= '0;
        ck_ras_q[i] <= '0;
      end
    end else if (restore_i) begin
      bhr_q <= ck_bhr_q;
      sp_q  <= ck_sp_q;
      for (int i = 0; i < RAS_D; i++) ras_q[i] <= ck_ras_q[i];
    end else begin
      if (save_i) begin
        ck_bhr_q <= bhr_q;
        ck_sp_q  <= sp_q;
        for (int i = 0; i < RAS_D; i++) ck_ras_q[i] <= ras_q[i];
      end
      if (br_i) bhr_q <= {bhr_q[BHR_W-2:0], taken_i};
      if (call_i) begin
        ras_q[sp_q] <= ret_addr_i;
        sp_q        <= sp_q + 1'b1;
      end else if (ret_i) begin
        sp_q <= sp_q - 1'b1;
      end
    end
  end

  assign bhr_o = bhr_q;
  assign top_o = ras_q[sp_q - 1'b1];

  // R8
  restore_bhr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> bhr_q == $past(ck_bhr_q));
  // R8
  restore_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> sp_q == $past(ck_sp_q));
endmodule

// File: rtl/miss_shadow_ctrl.sv
module miss_shadow_ctrl
  import msc_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int XLEN  = 16,
  parameter int PC_W  = 16,
  parameter int BHR_W = 8,
  parameter int RAS_D = 4,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_valid_i,
  input  logic [2:0]       head_op_i,
  input  logic [AW-1:0]    head_dst_i,
  input  logic [AW-1:0]    head_src_a_i,
  input  logic [AW-1:0]    head_src_b_i,
  input  logic [PC_W-1:0]  head_pc_i,
  input  logic             head_taken_i,
  input  logic             miss_i,
  input  logic [XLEN-1:0]  ld_data_i,
  input  logic             fill_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic             head_ready_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             rd_inv_o,
  output logic [BHR_W-1:0] bhr_o,
  output logic [PC_W-1:0]  ras_top_o,
  output logic             st_valid_o,
  output logic [XLEN-1:0]  st_addr_o,
  output logic [XLEN-1:0]  st_data_o,
  output logic             pf_valid_o,
  output logic [XLEN-1:0]  pf_addr_o,
  output logic [1:0]       mode_o,
  output logic             flush_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic [CNT_W-1:0] spec_cnt_o
);
  op_e   op;
  mode_e mode;
  logic  pop, enter, restore, spec;
  logic  is_add, is_load;
  logic [XLEN-1:0] da, db;
  logic  ia, ib, we, winv;
  logic [XLEN-1:0] wdata;

  assign op      = op_e'(head_op_i);
  assign is_add  = op == OP_ADD;
  assign is_load = op == OP_LOAD;
  assign spec    = mode == MODE_SPEC;

  msc_mode_fsm #(.PC_W(PC_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni,
    .head_valid_i, .is_load_i(is_load), .miss_i, .fill_i, .head_pc_i,
    .mode_o(mode), .pop_o(pop), .enter_o(enter), .restore_o(restore),
    .trig_pc_o(redirect_pc_o), .cnt_o(spec_cnt_o)
  );

  // poison: speculative results carry source invalid bits; trigger load always poisoned
  assign we    = pop && (is_add || is_load);
  assign wdata = is_add ? da + db : ld_data_i;
  always_comb begin
    winv = 1'b0;
    if (enter)             winv = 1'b1;
    else if (spec && is_add)  winv = ia | ib;
    else if (spec && is_load) winv = ia | miss_i;
  end

  msc_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(head_dst_i), .wdata_i(wdata), .winv_i(winv),
    .save_i(enter), .restore_i(restore),
    .ra_i(head_src_a_i), .rb_i(head_src_b_i), .rc_i(rd_addr_i),
    .da_o(da), .db_o(db), .dc_o(rd_data_o),
    .ia_o(ia), .ib_o(ib), .ic_o(rd_inv_o)
  );

  msc_hist #(.BHR_W(BHR_W), .RAS_D(RAS_D), .PC_W(PC_W)) u_hist (
    .clk_i, .rst_ni,
    .br_i(pop && op == OP_BRANCH), .taken_i(head_taken_i),
    .call_i(pop && op == OP_CALL), .ret_i(pop && op == OP_RET),
    .ret_addr_i(head_pc_i + PC_W'(4)),
    .save_i(enter), .restore_i(restore),
    .bhr_o, .top_o(ras_top_o)
  );

  assign head_ready_o = pop;
  assign st_valid_o   = pop && op == OP_STORE && mode == MODE_NORMAL;
  assign st_addr_o    = da;
  assign st_data_o    = db;
  assign pf_valid_o   = pop && spec && is_load && miss_i && !ia;
  assign pf_addr_o    = da;
  assign mode_o       = mode;
  assign flush_o      = restore;
  assign redirect_o   = restore;

  // R5
  no_spec_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode != MODE_NORMAL |-> !st_valid_o);
  // R6
  pf_only_spec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (spec && !ia));
  // R6
  no_reentry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec |-> !enter);
  // R7
  no_pop_restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore |-> !head_ready_o);
  // R4
  poison_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && spec && is_add && (ia || ib) && !fill_i) |=> u_rf.inv_q[$past(head_dst_i)]);
endmodule

// File: tb/sim_miss_shadow_ctrl.sv
module sim_miss_shadow_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic hv = 0, taken = 0, miss = 0, fill = 0;
  logic [2:0] op = 0, dst = 0, sa = 0, sb = 0, rda = 0;
  logic [15:0] pc = 0, ld = 0;
  logic ready, rinv, stv, pfv, flush, redir;
  logic [15:0] rdat, ras_top, sta, std, pfa, rpc, cnt;
  logic [7:0] bhr;
  logic [1:0] mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_rf [8], m_ck [8], m_ras [4], m_ckras [4];
  logic [7:0]  m_inv, m_bhr, m_ckbhr;
  logic [1:0]  m_sp, m_cksp, m_mode;
  logic [15:0] m_trig, m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  miss_shadow_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .head_valid_i(hv), .head_op_i(op),
    .head_dst_i(dst), .head_src_a_i(sa), .head_src_b_i(sb), .head_pc_i(pc),
    .head_taken_i(taken), .miss_i(miss), .ld_data_i(ld), .fill_i(fill),
    .rd_addr_i(rda), .head_ready_o(ready), .rd_data_o(rdat), .rd_inv_o(rinv),
    .bhr_o(bhr), .ras_top_o(ras_top), .st_valid_o(stv), .st_addr_o(sta),
    .st_data_o(std), .pf_valid_o(pfv), .pf_addr_o(pfa), .mode_o(mode),
    .flush_o(flush), .redirect_o(redir), .redirect_pc_o(rpc), .spec_cnt_o(cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_pop();
    return hv && (m_mode == 2'd0 || (m_mode == 2'd1 && !fill));
  endfunction

  task automatic check_and_update();
    logic p, ent;
    logic [15:0] sum;
    p = exp_pop();
    chk("R7 head_ready", ready, p);
    chk("R5 st_valid", stv, p && op == 3'd2 && m_mode == 2'd0);
    if (p && op == 3'd2 && m_mode == 2'd0) begin
      chk("R2 st_addr", sta, m_rf[sa]);
      chk("R2 st_data", std, m_rf[sb]);
    end
    chk("R6 pf_valid", pfv, p && m_mode == 2'd1 && op == 3'd1 && miss && !m_inv[sa]);
    if (pfv) chk("R6 pf_addr", pfa, m_rf[sa]);
    chk("R7 flush", flush, m_mode == 2'd2);
    chk("R7 redirect", redir, m_mode == 2'd2);
    if (m_mode == 2'd2) chk("R7 redirect_pc", rpc, m_trig);
    chk("R3 mode", mode, m_mode);
    chk("R9 spec_cnt", cnt, m_cnt);
    chk("R2 bhr", bhr, m_bhr);
    chk("R2 ras_top", ras_top, m_ras[m_sp - 2'd1]);
    chk("R8 rd_data", rdat, m_rf[rda]);
    chk("R4 rd_inv", rinv, m_inv[rda]);
    if (m_mode == 2'd2) begin
      for (int i = 0; i < 8; i++) m_rf[i] = m_ck[i];
      for (int i = 0; i < 4; i++) m_ras[i] = m_ckras[i];
      m_inv = '0; m_bhr = m_ckbhr; m_sp = m_cksp; m_mode = 2'd0;
    end else begin
      ent = p && m_mode == 2'd0 && op == 3'd1 && miss;
      if (ent) begin
        for (int i = 0; i < 8; i++) m_ck[i] = m_rf[i];
        for (int i = 0; i < 4; i++) m_ckras[i] = m_ras[i];
        m_ckbhr = m_bhr; m_cksp = m_sp; m_trig = pc; m_cnt = '0;
      end else if (m_mode == 2'd1 && p) m_cnt = m_cnt + 16'd1;
      if (p) begin
        sum = m_rf[sa] + m_rf[sb];
        case (op)
          3'd0: begin m_rf[dst] = sum; m_inv[dst] = (m_mode == 2'd1) && (m_inv[sa] | m_inv[sb]); end
          3'd1: begin
            m_inv[dst] = ent ? 1'b1 : (m_mode == 2'd1) && (m_inv[sa] | miss);
            m_rf[dst] = ld;
          end
          3'd3: m_bhr = {m_bhr[6:0], taken};
          3'd4: begin m_ras[m_sp] = pc + 16'd4; m_sp = m_sp + 2'd1; end
          3'd5: m_sp = m_sp - 2'd1;
          default: ;
        endcase
      end
      if (ent) m_mode = 2'd1;
      else if (m_mode == 2'd1 && fill) m_mode = 2'd2;
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] o, input logic [2:0] d,
                       input logic [2:0] a, input logic [2:0] b, input logic [15:0] p,
                       input logic t, input logic ms, input logic [15:0] data, input logic f);
    @(negedge clk);
    hv = v; op = o; dst = d; sa = a; sb = b; pc = p; taken = t; miss = ms; ld = data; fill = f;
    rda = 3'($urandom);
    #1 check_and_update();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_rf[i] = 0; m_ck[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_ras[i] = 0; m_ckras[i] = 0; end
    m_inv = 0; m_bhr = 0; m_ckbhr = 0; m_sp = 0; m_cksp = 0; m_mode = 0; m_trig = 0; m_cnt = 0;
    #(CLK_PERIOD * 2);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rda = 3'(i); #1;
      chk("R1 reset reg", rdat, 16'd0);
      chk("R1 reset inv", rinv, 1'b0);
    end
    chk("R1 reset mode", mode, 2'd0);
    chk("R1 reset bhr", bhr, 8'd0);
    chk("R1 reset ras", ras_top, 16'd0);
    chk("R1 reset cnt", cnt, 16'd0);
    @(negedge clk); rst_n = 1;
    // directed: r1=5, r4=9, miss into r2, poison chain, dropped store, prefetches, restore
    drive(1, 3'd1, 3'd1, 3'd0, 3'd0, 16'h0010, 0, 0, 16'd5, 0); // R2 load hit
    drive(1, 3'd1, 3'd4, 3'd0, 3'd0, 16'h0014, 0, 0, 16'd9, 0);
    drive(1, 3'd4, 3'd0, 3'd0, 3'd0, 16'h0018, 0, 0, 16'd0, 0); // R2 call
    drive(1, 3'd1, 3'd2, 3'd1, 3'd0, 16'h0040, 0, 1, 16'd7, 0); // R3 entry
    drive(1, 3'd0, 3'd3, 3'd2, 3'd1, 16'h0044, 0, 0, 16'd0, 0); // R4 poisoned add
    drive(1, 3'd2, 3'd0, 3'd1, 3'd4, 16'h0048, 0, 0, 16'd0, 0); // R5 store dropped
    drive(1, 3'd1, 3'd5, 3'd3, 3'd0, 16'h004c, 0, 1, 16'd0, 0); // R4 invalid address, no prefetch
    drive(1, 3'd1, 3'd6, 3'd4, 3'd0, 16'h0050, 0, 1, 16'd0, 0); // R6 prefetch at 9
    drive(1, 3'd3, 3'd0, 3'd0, 3'd0, 16'h0054, 1, 0, 16'd0, 0); // R8 spec history
    drive(1, 3'd0, 3'd1, 3'd4, 3'd4, 16'h0058, 0, 0, 16'd0, 0); // R4 valid result
    drive(1, 3'd0, 3'd7, 3'd0, 3'd0, 16'h005c, 0, 0, 16'd0, 1); // R7 fill blocks pop
    drive(1, 3'd0, 3'd7, 3'd0, 3'd0, 16'h005c, 0, 0, 16'd0, 0); // R7 restore cycle
    drive(1, 3'd1, 3'd2, 3'd1, 3'd0, 16'h0040, 0, 0, 16'd3, 1); // R8 refetched load, fill ignored
    drive(0, 3'd0, 3'd0, 3'd0, 3'd0, 16'h0000, 0, 0, 16'd0, 0);
    // random mix
    for (int n = 0; n < 6000; n++) begin
      logic f;
      f = (m_mode == 2'd1) ? ($urandom % 12 == 0) : ($urandom % 20 == 0);
      drive($urandom % 8 != 0, 3'($urandom % 6), 3'($urandom), 3'($urandom), 3'($urandom),
            16'($urandom), 1'($urandom), $urandom % 5 == 0, 16'($urandom), f);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule